// File: doc/BRIEF.md
# Interrupt Request Gateway

The gateway sits between one external interrupt source and the pending-bit logic of a central interrupt controller. It turns activity on the source into single requests. After a request has been raised, it raises no further request until the interrupt handler reports completion. The core acknowledges each request with an accept handshake. Once accepted, the request cannot be taken back. The source then stays quiet toward the core until a completion strobe arrives.

A mode input selects how the source is read. In level mode, an asserted line is a request. In edge mode, each rising transition of the line is one event, and so is each pulse on a separate message-signalled input. A build-time parameter picks what happens to edge events that arrive while a request is in flight. One variant drops them. The other stores them in a saturating counter, and the counter releases one new request per completion.

Top module: `irq_gateway`

## Requirements
- R1: After reset, `req_out` is 0 and no event is stored, so a completion or an accept that follows reset raises no request.
- R2: In level mode (`edge_mode`=0), when the gateway is idle and `irq_line` is 1 at a rising clock edge, `req_out` is 1 after that edge. It stays 1 until an edge at which `req_accept` is 1.
- R3: After an edge where `req_out` and `req_accept` are both 1, `req_out` stays 0 until a completion strobe, whatever the source does.
- R4: In level mode, if `irq_line` is still 1 at the edge where `done_strobe` is 1 for an accepted request, `req_out` is 1 after that edge.
- R5: A request is never withdrawn. If `irq_line` drops while `req_out` waits for accept, `req_out` stays 1. If the line is 0 at completion in level mode, the gateway returns to idle with `req_out`=0.
- R6: In edge mode (`edge_mode`=1), a 0-to-1 change of `irq_line` between two sampling edges is one event. An event in idle raises `req_out` after that edge. A line held at 1 raises nothing more.
- R7: With `COUNT_EDGES`=1, events that arrive while a request is in flight are counted, including an event at the same edge as the completion. The count drops by one when the core accepts a request. At each completion with a nonzero count, `req_out` is 1 after the completion edge.
- R8: The stored event count saturates at 2^`CNT_W`-1 (3 for the default `CNT_W`=2) and does not wrap.
- R9: With `COUNT_EDGES`=0, events that arrive while a request is in flight are dropped. A completion then returns the gateway to idle.
- R10: A 1 on `msg_pulse` at a sampling edge is an edge event in edge mode and has no effect in level mode.
- R11: `done_strobe` has no effect while the gateway is idle or while `req_out` waits for accept.
- R12: `req_accept` has no effect while `req_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| edge_mode | input | 1 | 1 = edge-style source, 0 = level source; held static during operation |
| irq_line | input | 1 | Raw interrupt line, synchronous to `clk` |
| msg_pulse | input | 1 | One-cycle message-signalled interrupt pulse |
| done_strobe | input | 1 | Handler completion, one cycle |
| req_accept | input | 1 | Core accepts the current request |
| req_out | output | 1 | Request toward the pending bit |

## Verification
Every result of this block appears exactly one clock after the rising edge that samples its cause. A line change, a pulse, an accept or a completion driven before edge N shows on `req_out` after edge N. The bench drives all inputs on the falling edge. For each driven cycle it queues the expected `req_out` of both variant instances, and a monitor compares them 5 ns after the next rising edge. This keeps every comparison on the single cycle in which the result is due. Sequences are built so that counted, dropped and saturated events show up as a request that is present or missing right after a completion.

// File: rtl/irq_gw_pkg.sv
// Shared types for the interrupt request gateway.
// Assumes: nothing beyond the 1800-2017 language.
package irq_gw_pkg;

    // Gateway life cycle of a single request.
    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,   // nothing outstanding
        GW_REQ  = 2'd1,   // request raised, waiting for core accept
        GW_WAIT = 2'd2    // accepted, waiting for handler completion
    } gw_state_e;

endpackage

// File: rtl/irq_gw_detect.sv
// Source front end: turns the raw line and the message pulse into
// an edge-style event and a level-style request.
// Assumes: irq_line and msg_pulse are already synchronous to clk.
module irq_gw_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic irq_line,
    input  logic msg_pulse,
    output logic edge_ev,
    output logic level_req
);

    logic line_q;

    // Remember the line value of the previous sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= irq_line;
    end

    // A rising transition or a message pulse is an event in edge mode only.
    always_comb begin
        edge_ev   = edge_mode & ((irq_line & ~line_q) | msg_pulse);
        level_req = ~edge_mode & irq_line;
    end

endmodule

// File: rtl/irq_gw_store.sv
// Event store: holds edge events that have not yet been accepted by the
// core. COUNT_EDGES selects a saturating counter or a single flag that
// only arms while idle (surplus events dropped).
// Assumes: take is only raised while at least one event is stored.
module irq_gw_store #(
    parameter int CNT_W       = 2,
    parameter bit COUNT_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_ev,
    input  logic in_flight,
    input  logic take,
    output logic avail
);

    logic inc;

    // An event is stored when counting, or when nothing is in flight.
    always_comb inc = edge_ev & (COUNT_EDGES | ~in_flight);

    generate
        if (COUNT_EDGES) begin : g_count
            localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
            localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
            logic [CNT_W-1:0] cnt_q;

            // Saturating up/down count of unaccepted events.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (inc && !take) begin
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
                end else if (take && !inc) begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
                end
            end

            // Work is available if something is stored or arrives now.
            always_comb avail = (cnt_q != '0) | inc;
        end else begin : g_drop
            logic flag_q;

            // Single stored event; set in idle, cleared on accept.
            always_ff @(posedge clk) begin
                if (!rst_n)    flag_q <= 1'b0;
                else if (inc)  flag_q <= 1'b1;
                else if (take) flag_q <= 1'b0;
            end

            // Work is available if the flag is set or arms now.
            always_comb avail = flag_q | inc;
        end
    endgenerate

endmodule

// File: rtl/irq_gw_ctrl.sv
// Request control: idle -> raised -> accepted -> (completion) -> idle or
// raised again. Exactly one request is outstanding at a time.
// Assumes: edge_mode does not change while a request is in flight.
module irq_gw_ctrl
    import irq_gw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      edge_mode,
    input  logic      level_req,
    input  logic      edge_avail,
    input  logic      done_strobe,
    input  logic      req_accept,
    output gw_state_e state,
    output logic      take,
    output logic      req_out
);

    gw_state_e state_d;
    logic      want;

    // A new request is wanted from a held level or a stored/new event.
    always_comb want = level_req | (edge_mode & edge_avail);

    // Next-state decision.
    always_comb begin
        state_d = state;
        unique case (state)
            GW_IDLE: if (want)        state_d = GW_REQ;
            GW_REQ:  if (req_accept)  state_d = GW_WAIT;
            GW_WAIT: if (done_strobe) state_d = want ? GW_REQ : GW_IDLE;
            default:                  state_d = GW_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GW_IDLE;
        else        state <= state_d;
    end

    // Request output and the accept that consumes a stored event.
    always_comb begin
        req_out = (state == GW_REQ);
        take    = req_out & req_accept & edge_mode;
    end

endmodule

// File: rtl/irq_gateway.sv
// Interrupt request gateway top: front end, event store and request
// control for one source.
// Assumes: all inputs synchronous to clk; done_strobe and req_accept are
// single-cycle strobes from the controller side.
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int CNT_W       = 2,
    parameter bit COUNT_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic irq_line,
    input  logic msg_pulse,
    input  logic done_strobe,
    input  logic req_accept,
    output logic req_out
);

    logic      edge_ev;
    logic      level_req;
    logic      edge_avail;
    logic      take;
    logic      in_flight;
    gw_state_e state;

    // Anything other than idle counts as a request in flight.
    always_comb in_flight = (state != GW_IDLE);

    irq_gw_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .irq_line  (irq_line),
        .msg_pulse (msg_pulse),
        .edge_ev   (edge_ev),
        .level_req (level_req)
    );

    irq_gw_store #(
        .CNT_W       (CNT_W),
        .COUNT_EDGES (COUNT_EDGES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_ev   (edge_ev),
        .in_flight (in_flight),
        .take      (take),
        .avail     (edge_avail)
    );

    irq_gw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_mode   (edge_mode),
        .level_req   (level_req),
        .edge_avail  (edge_avail),
        .done_strobe (done_strobe),
        .req_accept  (req_accept),
        .state       (state),
        .take        (take),
        .req_out     (req_out)
    );

endmodule

// File: rtl/irq_gateway_chk.sv
// Port-level protocol checker for irq_gateway, attached by bind.
// Assumes: edge_mode static; tracks acceptance from the ports only.
module irq_gateway_chk (
    input logic clk,
    input logic rst_n,
    input logic edge_mode,
    input logic irq_line,
    input logic msg_pulse,
    input logic done_strobe,
    input logic req_accept,
    input logic req_out
);

    logic awaiting;

    // Set on an accepted request, cleared by the completion that ends it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        awaiting <= 1'b0;
        else if (req_out && req_accept)    awaiting <= 1'b1;
        else if (awaiting && done_strobe)  awaiting <= 1'b0;
    end

    // R5: a raised request is never withdrawn before accept.
    a_r5_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_out && !req_accept |=> req_out);

    // R3: an accepted request drops at once.
    a_r3_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_out && req_accept |=> !req_out);

    // R3: no request while waiting for completion.
    a_r3_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        awaiting && !done_strobe |=> !req_out);

    // R4: level still high at completion re-requests.
    a_r4_level_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        awaiting && done_strobe && !edge_mode && irq_line |=> req_out);

    // R2: level high while idle raises a request.
    a_r2_level_request: assert property (@(posedge clk) disable iff (!rst_n)
        !awaiting && !req_out && !edge_mode && irq_line |=> req_out);

    // R11: completion in idle with no event raises nothing.
    a_r11_done_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !awaiting && !req_out && done_strobe && edge_mode && !irq_line && !msg_pulse
        |=> !req_out);

endmodule

bind irq_gateway irq_gateway_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_mode   (edge_mode),
    .irq_line    (irq_line),
    .msg_pulse   (msg_pulse),
    .done_strobe (done_strobe),
    .req_accept  (req_accept),
    .req_out     (req_out)
);

// File: tb/sim_irq_gateway.sv
// Scoreboard bench: u0 counts surplus events, u1 drops them.
module sim_irq_gateway;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic edge_mode = 1'b0;
    logic irq_line = 1'b0;
    logic msg_pulse = 1'b0;
    logic done_strobe = 1'b0;
    logic req_accept = 1'b0;
    logic req0, req1;
    logic cur_mode = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  e0;
        logic  e1;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_gateway #(.CNT_W(2), .COUNT_EDGES(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .irq_line(irq_line),
        .msg_pulse(msg_pulse), .done_strobe(done_strobe), .req_accept(req_accept),
        .req_out(req0));

    irq_gateway #(.CNT_W(2), .COUNT_EDGES(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .irq_line(irq_line),
        .msg_pulse(msg_pulse), .done_strobe(done_strobe), .req_accept(req_accept),
        .req_out(req1));

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input logic ln, input logic ms, input logic dn,
                        input logic ac, input logic x0, input logic x1,
                        input string tag);
        exp_t it;
        @(negedge clk);
        edge_mode   = cur_mode;
        irq_line    = ln;
        msg_pulse   = ms;
        done_strobe = dn;
        req_accept  = ac;
        it.e0 = x0;
        it.e1 = x1;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_cmp += 2;
                if (req0 !== it.e0) begin
                    n_bad++;
                    $display("FAIL %s u0 req_out=%0b expected %0b", it.tag, req0, it.e0);
                end
                if (req1 !== it.e1) begin
                    n_bad++;
                    $display("FAIL %s u1 req_out=%0b expected %0b", it.tag, req1, it.e1);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Level mode
        step(0,0,0,0, 0,0, "R1 reset idle");
        step(0,0,1,1, 0,0, "R1 strobes after reset");
        step(1,0,0,0, 1,1, "R2 level raises");
        step(1,0,0,0, 1,1, "R2 held until accept");
        step(0,0,0,0, 1,1, "R5 line drop no withdraw");
        step(0,0,0,1, 0,0, "R3 accept drops req");
        step(1,0,0,0, 0,0, "R3 quiet while waiting");
        step(0,0,0,0, 0,0, "R3 quiet while waiting");
        step(0,0,1,0, 0,0, "R5 done with line low");
        step(0,0,0,0, 0,0, "R5 idle after done");
        step(1,0,0,0, 1,1, "R2 level raises again");
        step(1,0,0,1, 0,0, "R3 accept");
        step(1,0,1,0, 1,1, "R4 level still high at done");
        step(1,0,0,1, 0,0, "R3 accept");
        step(0,0,1,0, 0,0, "R5 done line low");
        step(0,1,0,0, 0,0, "R10 msg ignored in level mode");
        step(0,0,1,0, 0,0, "R11 done ignored idle");
        step(0,0,0,1, 0,0, "R12 accept ignored idle");
        step(1,0,0,0, 1,1, "R12 still idle before");
        step(1,0,1,0, 1,1, "R11 done ignored before accept");
        step(0,0,0,1, 0,0, "R3 accept");
        step(0,0,1,0, 0,0, "R5 done to idle");
        // Edge mode
        cur_mode = 1'b1;
        step(0,0,0,0, 0,0, "R6 edge idle");
        step(1,0,0,0, 1,1, "R6 rising edge");
        step(1,0,0,0, 1,1, "R6 held");
        step(1,0,0,1, 0,0, "R3 accept");
        step(1,0,1,0, 0,0, "R6 held line no rerequest");
        step(1,0,0,0, 0,0, "R6 held line no event");
        step(0,0,0,0, 0,0, "R6 low");
        step(1,0,0,0, 1,1, "R6 edge");
        step(0,0,0,0, 1,1, "R6 held req");
        step(1,0,0,0, 1,1, "R7 edge while raised");
        step(0,0,0,1, 0,0, "R7 accept");
        step(1,0,0,0, 0,0, "R7 edge while waiting");
        step(0,0,0,0, 0,0, "R3 quiet");
        step(0,0,1,0, 1,0, "R7/R9 done releases stored");
        step(0,0,0,1, 0,0, "R7 accept");
        step(0,0,1,0, 1,0, "R7/R9 done releases second");
        step(0,0,0,1, 0,0, "R7 accept");
        step(0,0,1,0, 0,0, "R7 drained");
        step(0,0,0,0, 0,0, "R7 idle");
        step(0,1,0,0, 1,1, "R10 msg raises");
        step(0,0,0,1, 0,0, "R3 accept");
        step(0,1,0,0, 0,0, "R10 msg while waiting");
        step(0,0,1,0, 1,0, "R10/R9 msg stored or dropped");
        step(0,0,0,1, 0,0, "R3 accept");
        step(0,0,1,0, 0,0, "R7 drained");
        // Saturation: five edges, counter holds at 3
        step(1,0,0,0, 1,1, "R8 edge 1");
        step(0,0,0,0, 1,1, "R8");
        step(1,0,0,0, 1,1, "R8 edge 2");
        step(0,0,0,0, 1,1, "R8");
        step(1,0,0,0, 1,1, "R8 edge 3");
        step(0,0,0,0, 1,1, "R8");
        step(1,0,0,0, 1,1, "R8 edge 4");
        step(0,0,0,0, 1,1, "R8");
        step(1,0,0,0, 1,1, "R8 edge 5");
        step(0,0,0,1, 0,0, "R8 accept");
        step(0,0,1,0, 1,0, "R8 release 2");
        step(0,0,0,1, 0,0, "R8 accept");
        step(0,0,1,0, 1,0, "R8 release 3");
        step(0,0,0,1, 0,0, "R8 accept");
        step(0,0,1,0, 0,0, "R8 saturated count drained");
        // Event coincident with completion
        step(1,0,0,0, 1,1, "R6 edge");
        step(0,0,0,1, 0,0, "R3 accept");
        step(1,0,1,0, 1,0, "R7/R9 edge at completion");
        step(0,0,0,1, 0,0, "R12 accept u0, ignored u1");
        step(0,0,1,0, 0,0, "R7 drained");
        step(0,0,0,0, 0,0, "R1 idle end");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule